// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is the slave side of a two-wire serial memory holding 256 bytes. It runs on the system clock and takes SCL and SDA as samples that are already synchronized to that clock. It drives SDA only as an open-drain pull-down. From the line samples it finds start and stop conditions and bit edges. It checks the control byte, keeps a byte address pointer, returns bytes in sequence on reads, and collects write data in an eight-byte page buffer.

The buffered bytes are committed to the internal store when the stop condition arrives. A self-timed write cycle of a parameterised number of system clocks follows. While that cycle runs, the slave refuses every transfer by never acknowledging. A level input acts as a write enable. A write is programmed only when this input stayed high through the whole transfer. The bus itself has no back-pressure, since the slave never stretches SCL. The master's acknowledge on reads is the only flow control.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A start at any moment, including in the middle of a byte, restarts control-byte matching. A stop releases SDA.
- R2: Bytes are sent most significant bit first. The control byte is the seven bits 1010000 followed by a direction bit in bit 0 (1 = read, 0 = write). When the code matches, the slave acknowledges by pulling SDA low for the whole high phase of the ninth clock. Any other code gets no acknowledge, and the rest of that transfer is ignored until the next start.
- R3: In a write, the byte after the control byte loads the address pointer, and every byte of the write is acknowledged.
- R4: Each write data byte goes to buffer slot pointer[2:0]. Only pointer[2:0] then increments modulo 8, and pointer[7:3] does not change.
- R5: With more than eight data bytes, the slot index wraps within the page. Later bytes replace earlier ones, and only the final content of each slot is programmed.
- R6: Buffered data reaches the store only on a stop. Only the page bytes that were written change. A start before the stop discards the buffered data without programming it.
- R7: After a commit, a write cycle of WR_CYCLES clocks runs. During this cycle the slave acknowledges nothing, not even its own control byte.
- R8: A commit needs the write-enable input high on every clock from the start up to and including the clock in which the stop is seen. Otherwise the bytes are still acknowledged, but the store is unchanged and no write cycle begins. Dropping the input during the write cycle does not stop programming.
- R9: In a read, the slave sends the byte at the pointer, changing SDA only after SCL falls. The pointer then increments over the full 8-bit range and wraps from FFh to 00h.
- R10: A master acknowledge on a read byte fetches the next byte. A master no-acknowledge makes the slave release SDA and leave it released until the next start or stop.
- R11: After reset, SDA is released, the store reads all zero, and no write cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized sample of the serial clock line |
| sda_in | input | 1 | Synchronized sample of the serial data line |
| wren_in | input | 1 | Write-enable level that gates programming |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can fall in the same system clock. One is the stop detection that would commit a page. The other is the sampling of the write-enable level that decides whether the commit is allowed. The bench releases SDA for the stop and drops the enable on the same clock. It then checks two results: the target byte must read back unchanged, and an immediate control byte must be acknowledged, which proves that no write cycle started. A second collision is a control byte that arrives right after a commit, while the write cycle timer is still counting. The bench checks that this byte is refused, and that the same probe is acknowledged once the cycle has run out.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam logic [6:0] DEV_CODE = 7'b1010000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_MUTE
  } phase_t;
endpackage

// File: rtl/tw_line_watch.sv
module tw_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  // SDA edges are only conditions when SCL stayed high across the sample pair
  assign start_o = scl_q & scl_in & sda_q & ~sda_in;
  assign stop_o  = scl_q & scl_in & ~sda_q & sda_in;
  assign rise_o  = ~scl_q & scl_in;
  assign fall_o  = scl_q & ~scl_in;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf
  import tw_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear_i,
  input  logic                              wr_i,
  input  logic [PAGE_W-1:0]                 idx_i,
  input  logic [BYTE_W-1:0]                 din_i,
  output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] data_o,
  output logic [(1<<PAGE_W)-1:0]            mask_o
);
  localparam int SLOTS = 1 << PAGE_W;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[k] <= '0;
        mask_o[k] <= 1'b0;
      end else if (clear_i) begin
        mask_o[k] <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(k)) begin
        data_o[k] <= din_i;
        mask_o[k] <= 1'b1;
      end
    end

    // R5: a write to a slot leaves it marked and holding the newest byte
    a_r5_slot_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clear_i && idx_i == PAGE_W'(k)) |=> (mask_o[k] && data_o[k] == $past(din_i)));
  end
endmodule

// File: rtl/tw_store.sv
module tw_store
  import tw_pkg::*;
#(
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 2000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]          page_i,
  input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] pdata_i,
  input  logic [(1<<PAGE_W)-1:0]            pmask_i,
  input  logic [ADDR_W-1:0]                 raddr_i,
  output logic [BYTE_W-1:0]                 rdata_o,
  output logic                              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit_i) begin
      for (int k = 0; k < SLOTS; k++)
        if (pmask_i[k]) mem[{page_i, PAGE_W'(k)}] <= pdata_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (commit_i)   cnt <= CNT_W'(WR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o  = (cnt != '0);
  assign rdata_o = mem[raddr_i];

  // R7: the front end never asks for a commit while a write cycle runs
  a_r7_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !busy_o);
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
  import tw_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     rise_i,
  input  logic                     fall_i,
  input  logic                     sda_i,
  input  logic                     wren_i,
  input  logic                     busy_i,
  input  logic [BYTE_W-1:0]        rdata_i,
  output logic                     sda_pull_o,
  output logic [ADDR_W-1:0]        ptr_o,
  output logic                     buf_clear_o,
  output logic                     buf_wr_o,
  output logic [PAGE_W-1:0]        buf_idx_o,
  output logic [BYTE_W-1:0]        buf_din_o,
  output logic                     commit_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o
);
  phase_t            phase;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [ADDR_W-1:0] ptr;
  logic              rw, pull, we_ok, have_data, active;

  assign active = (phase == PH_CTRL) || (phase == PH_ADDR) ||
                  (phase == PH_WDATA) || (phase == PH_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      pull      <= 1'b0;
      we_ok     <= 1'b0;
      have_data <= 1'b0;
    end else if (start_i) begin
      phase     <= PH_CTRL;
      bitcnt    <= '0;
      pull      <= 1'b0;
      we_ok     <= wren_i;
      have_data <= 1'b0;
    end else if (stop_i) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      pull      <= 1'b0;
      we_ok     <= 1'b0;
      have_data <= 1'b0;
    end else begin
      we_ok <= we_ok & wren_i;
      if (active && rise_i) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (phase != PH_RDATA) shreg <= {shreg[BYTE_W-2:0], sda_i};
        end else if (bitcnt == 4'd9 && phase == PH_RDATA && sda_i) begin
          phase <= PH_MUTE;
        end
      end else if (active && fall_i) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (phase)
            PH_CTRL: begin
              if (shreg[BYTE_W-1:1] == DEV_CODE && !busy_i) begin
                pull <= 1'b1;
                rw   <= shreg[0];
              end else begin
                phase <= PH_MUTE;
              end
            end
            PH_ADDR: pull <= 1'b1;
            PH_WDATA: begin
              pull      <= 1'b1;
              have_data <= 1'b1;
              ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
            end
            default: pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          pull   <= 1'b0;
          case (phase)
            PH_CTRL: begin
              if (rw) begin
                phase <= PH_RDATA;
                shreg <= rdata_i;
                ptr   <= ptr + 1'b1;
                pull  <= ~rdata_i[BYTE_W-1];
              end else begin
                phase <= PH_ADDR;
              end
            end
            PH_ADDR: begin
              ptr   <= shreg;
              phase <= PH_WDATA;
            end
            PH_RDATA: begin
              shreg <= rdata_i;
              ptr   <= ptr + 1'b1;
              pull  <= ~rdata_i[BYTE_W-1];
            end
            default: ;
          endcase
        end else if (phase == PH_RDATA && bitcnt != 4'd0) begin
          pull  <= ~shreg[BYTE_W-2];
          shreg <= {shreg[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sda_pull_o  = pull;
  assign ptr_o       = ptr;
  assign buf_clear_o = start_i | stop_i;
  assign buf_wr_o    = fall_i & ~start_i & ~stop_i & (phase == PH_WDATA) & (bitcnt == 4'd8);
  assign buf_idx_o   = ptr[PAGE_W-1:0];
  assign buf_din_o   = shreg;
  assign page_o      = ptr[ADDR_W-1:PAGE_W];
  assign commit_o    = stop_i & (phase == PH_WDATA) & have_data & we_ok & wren_i & ~busy_i;

  // R1: SDA is free in the clock after a stop
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_pull_o);

  // R4: the page part of the pointer holds while data bytes are collected
  a_r4_page_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WDATA) |=> $stable(ptr[ADDR_W-1:PAGE_W]));

  // R10: an ignored or finished transfer never drives the line
  a_r10_mute_released: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MUTE) |-> !sda_pull_o);
endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
  import tw_pkg::*;
#(
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wren_in,
  output logic sda_pull
);
  localparam int SLOTS = 1 << PAGE_W;

  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic buf_clear, buf_wr, commit, busy;
  logic [PAGE_W-1:0]          buf_idx;
  logic [BYTE_W-1:0]          buf_din, rdata;
  logic [ADDR_W-1:0]          ptr;
  logic [ADDR_W-PAGE_W-1:0]   page;
  logic [SLOTS-1:0][BYTE_W-1:0] pdata;
  logic [SLOTS-1:0]           pmask;

  tw_line_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_o(start_evt), .stop_o(stop_evt), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  tw_slave_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_evt), .stop_i(stop_evt), .rise_i(scl_rise), .fall_i(scl_fall),
    .sda_i(sda_in), .wren_i(wren_in), .busy_i(busy), .rdata_i(rdata),
    .sda_pull_o(sda_pull), .ptr_o(ptr),
    .buf_clear_o(buf_clear), .buf_wr_o(buf_wr), .buf_idx_o(buf_idx), .buf_din_o(buf_din),
    .commit_o(commit), .page_o(page)
  );

  tw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(buf_clear), .wr_i(buf_wr),
    .idx_i(buf_idx), .din_i(buf_din), .data_o(pdata), .mask_o(pmask)
  );

  tw_store #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(page),
    .pdata_i(pdata), .pmask_i(pmask), .raddr_i(ptr), .rdata_o(rdata), .busy_o(busy)
  );

  // R7: no acknowledge or data drive while the write cycle runs
  a_r7_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R6: programming is only ever launched by a stop condition
  a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_evt);
endmodule

// File: tb/twowire_eeprom_slave_bench.sv
module twowire_eeprom_slave_bench;
  localparam int WRC  = 600;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wren = 1'b1;
  logic sda_pull;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] pat [16];
  logic [7:0] rb [16];

  assign sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  twowire_eeprom_slave #(.WR_CYCLES(WRC)) u_twowire_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .wren_in(wren), .sda_pull(sda_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(1);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(1);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic v);
    sda_m = v; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF / 2);
    ack = ~sda_line;
    tick(HALF - HALF / 2);
    scl_m = 1'b0; tick(1);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl_m = 1'b1; tick(HALF / 2);
      b[i] = sda_line;
      tick(HALF - HALF / 2);
      scl_m = 1'b0; tick(1);
    end
    sda_m = ~mack; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic probe(output logic ack);
    bus_start();
    send_byte(8'hA0, ack);
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk({tag, " ctrl ack"}, ack, 1);
    send_byte(addr, ack);  chk({tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat[i], ack); chk({tag, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] addr, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk({tag, " rd ctrl ack"}, ack, 1);
    send_byte(addr, ack);  chk({tag, " rd addr ack"}, ack, 1);
    bus_start();
    send_byte(8'hA1, ack); chk({tag, " rd dir ack"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11 SDA released after reset", sda_pull, 0);
    read_at(8'h00, 1, "R11");
    chk("R11 store reads zero", rb[0], 8'h00);
  endtask

  task automatic t_byte_write_busy();
    logic ack;
    pat[0] = 8'hA5;
    do_write(8'h10, 1, "R3");
    tick(WRC / 2);
    probe(ack);
    chk("R7 no ack during write cycle", ack, 0);
    tick(WRC);
    probe(ack);
    chk("R7 ack after write cycle", ack, 1);
    read_at(8'h10, 1, "R6");
    chk("R6 byte committed", rb[0], 8'hA5);
  endtask

  task automatic t_page_wrap();
    pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33; pat[3] = 8'h44;
    do_write(8'h25, 4, "R4");
    tick(WRC + 20);
    read_at(8'h20, 8, "R4");
    chk("R4 slot 0 wrapped", rb[0], 8'h44);
    for (int i = 1; i <= 4; i++) chk("R4 untouched in page", rb[i], 8'h00);
    chk("R4 slot 5", rb[5], 8'h11);
    chk("R4 slot 6", rb[6], 8'h22);
    chk("R4 slot 7", rb[7], 8'h33);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) pat[i] = 8'h50 + 8'(i);
    do_write(8'h40, 10, "R5");
    tick(WRC + 20);
    read_at(8'h40, 8, "R5");
    chk("R5 slot 0 overwritten", rb[0], 8'h58);
    chk("R5 slot 1 overwritten", rb[1], 8'h59);
    for (int i = 2; i < 8; i++) chk("R5 slot kept", rb[i], 8'h50 + 8'(i));
  endtask

  task automatic t_bad_code();
    logic ack;
    bus_start();
    send_byte(8'hA2, ack); chk("R2 wrong code no ack", ack, 0);
    send_byte(8'h30, ack); chk("R2 rest ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB0, ack); chk("R2 wrong code no ack", ack, 0);
    bus_stop();
  endtask

  task automatic t_wren_low_mid();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R8 ctrl ack", ack, 1);
    send_byte(8'h30, ack); chk("R8 addr ack", ack, 1);
    wren = 1'b0; tick(3); wren = 1'b1;
    send_byte(8'h77, ack); chk("R8 data still acked", ack, 1);
    bus_stop();
    probe(ack);
    chk("R8 no write cycle", ack, 1);
    read_at(8'h30, 1, "R8");
    chk("R8 store unchanged", rb[0], 8'h00);
  endtask

  task automatic t_wren_drop_at_stop();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R8 ctrl ack", ack, 1);
    send_byte(8'h31, ack); chk("R8 addr ack", ack, 1);
    send_byte(8'h66, ack); chk("R8 data ack", ack, 1);
    sda_m = 1'b0; tick(1);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; wren = 1'b0; tick(1);
    wren = 1'b1; tick(HALF);
    probe(ack);
    chk("R8 same-clock drop no write cycle", ack, 1);
    read_at(8'h31, 1, "R8");
    chk("R8 same-clock drop unchanged", rb[0], 8'h00);
  endtask

  task automatic t_wren_during_cycle();
    pat[0] = 8'h5A;
    do_write(8'h32, 1, "R8");
    wren = 1'b0; tick(WRC / 3); wren = 1'b1;
    tick(WRC);
    read_at(8'h32, 1, "R8");
    chk("R8 cycle not aborted", rb[0], 8'h5A);
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R1 ctrl ack", ack, 1);
    send_byte(8'h60, ack); chk("R1 addr ack", ack, 1);
    send_byte(8'h11, ack); chk("R1 data ack", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hA0, ack); chk("R1 match after mid-byte start", ack, 1);
    send_byte(8'h60, ack); chk("R1 addr ack", ack, 1);
    bus_stop();
    chk("R1 SDA released after stop", sda_pull, 0);
    probe(ack);
    chk("R6 discarded data no write cycle", ack, 1);
    read_at(8'h60, 1, "R6");
    chk("R6 discarded data not stored", rb[0], 8'h00);
  endtask

  task automatic t_read_wrap();
    pat[0] = 8'h3C; pat[1] = 8'hC3;
    do_write(8'hFE, 2, "R9");
    tick(WRC + 20);
    read_at(8'hFE, 3, "R9");
    chk("R9 byte FE", rb[0], 8'h3C);
    chk("R9 byte FF", rb[1], 8'hC3);
    chk("R9 wrap to 00", rb[2], 8'h00);
  endtask

  task automatic t_nack_release();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hA0, ack); chk("R10 ctrl ack", ack, 1);
    send_byte(8'h10, ack); chk("R10 addr ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack); chk("R10 dir ack", ack, 1);
    recv_byte(1'b0, b);
    chk("R10 read data", b, 8'hA5);
    for (int p = 0; p < 2; p++) begin
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF / 2);
      chk("R10 SDA released after nack", sda_line, 1);
      tick(HALF - HALF / 2);
      scl_m = 1'b0; tick(1);
    end
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_byte_write_busy();
    t_page_wrap();
    t_overflow();
    t_bad_code();
    t_wren_low_mid();
    t_wren_drop_at_stop();
    t_wren_during_cycle();
    t_abort();
    t_read_wrap();
    t_nack_release();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule